// File: doc/BRIEF.md
# High-Resolution Mode Command Sequencer

This block drives a three-wire peripheral link (a clock line and a latch line going out, a data line coming in) through the fixed handshake that puts the peripheral into its high-resolution reporting mode. When a start pulse arrives while the block is idle, it performs a sequence of timed steps. It first gives a short latch pulse. It then runs four read clock pulses, whose returned bits are not used, so the data line is not an input of this block. Next come two long setup holds: a quiet one with the latch low, then one with the latch high. After that it sends a fixed seven-byte command serially on the latch wire, and it finishes with a tail wait and a long recovery wait. The latch wire therefore doubles as the command's serial output line.

Every duration is a cycle count that the block computes from the `CLK_HZ` parameter. A duration of D microseconds becomes C(D) = ceil(D * CLK_HZ / 1e6) cycles, and never less than one cycle. The normal packet reader is a separate block, and a multiplexer outside this block decides which of the two owns the lines. `busy_o` marks the time during which this block owns them.

Top module: `mode_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `line_clk_o` = 1, `line_lat_o` = 0, `busy_o` = 0, `done_o` = 0. A reset in the middle of a sequence abandons it.
- R2: When `start_i` is high at a clock edge while idle, `busy_o` goes high after that edge. `line_lat_o` is then high for C(5) cycles with `line_clk_o` high.
- R3: After the latch pulse, the block gives exactly four read clock pulses, each low for C(1) cycles and then high for C(1) cycles, with the latch low. The first low phase starts when the latch falls. `line_clk_o` is never low while `busy_o` is low.
- R4: The quiet hold follows the high phase of the last read pulse. In it the clock is high and the latch low for C(7212) cycles, so the latch rises C(1)+C(7212) cycles after the fourth clock rise. The latch then stays high for C(2260) cycles.
- R5: The command is 56 further clock pulses. The latch value seen at each rising clock edge gives the bytes 0x06, 0xC1, 0x08, 0x00, 0x02, 0xFF, 0x01 in that order, most significant bit first. Each bit is put on the latch C(1) cycles before the clock falls.
- R6: `line_lat_o` never changes while `line_clk_o` is low.
- R7: Consecutive command clock rises are C(22) cycles apart within a byte and C(96) cycles apart between the last bit of one byte and the first bit of the next.
- R8: The latch falls C(892) cycles after the final command clock rise. `done_o` rises C(60000) cycles after that fall.
- R9: `done_o` is high for exactly one cycle, in the first cycle that `busy_o` is low again. A full sequence keeps `busy_o` high for C(5) + 8·C(1) + C(7212) + C(2260) + 112·C(1) + 49·(C(22)−2·C(1)) + 6·(C(96)−2·C(1)) + C(892) + C(60000) cycles.
- R10: `start_i` has no effect while `busy_o` is high: the sequence length, the pulse count and the command bytes do not change, and a single `done_o` pulse ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the mode-switch sequence when idle |
| busy_o | output | 1 | High while the sequence owns the lines |
| done_o | output | 1 | One-cycle pulse at the end of the recovery wait |
| line_clk_o | output | 1 | Clock line to the peripheral, high when idle |
| line_lat_o | output | 1 | Latch line, also the serial command output |

## Verification
The hardest case to create from the ports is a `start_i` pulse that arrives while the sequencer is deep inside a long hold or on the last cycle of the recovery wait. In either case a wrongly accepted start would shorten or restart the sequence. The bench toggles `start_i` at random throughout the busy time of some runs. It then compares the busy length, the clock-pulse count, the decoded command bytes and every measured spacing against values it computes itself. A reset in the middle of a run is also applied, and a clean run follows it.

// File: rtl/mode_cmd_pkg.sv
`timescale 1ns/1ps
// Shared constants, state encoding and helper functions for the
// mode-switch command sequencer. Assumes an 8-bit command word.
package mode_cmd_pkg;

    localparam int CMD_LEN   = 7;
    localparam int CMD_W     = 8;
    localparam int READ_BITS = 4;
    localparam int BYTE_CW   = $clog2(CMD_LEN);
    localparam int BIT_CW    = $clog2(CMD_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LATCH,
        ST_RD_LO,
        ST_RD_HI,
        ST_HOLD_LO,
        ST_HOLD_HI,
        ST_BIT_SET,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_RECOV
    } seq_st_t;

    // Command byte at position idx, sent in ascending index order.
    function automatic logic [CMD_W-1:0] cmd_byte(input int idx);
        case (idx)
            0:       return 8'h06;
            1:       return 8'hC1;
            2:       return 8'h08;
            3:       return 8'h00;
            4:       return 8'h02;
            5:       return 8'hFF;
            6:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Microseconds to clock cycles, rounded up, never below one.
    function automatic int unsigned us2cyc(input longint unsigned hz,
                                           input longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/mode_cmd_timer.sv
`timescale 1ns/1ps
// Down-counting interval timer. A load of D-1 makes the owning
// state last D cycles; zero_o is high in the last cycle of the interval.
// Assumes the loaded value fits in W bits.
module mode_cmd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mode_cmd_rom.sv
`timescale 1ns/1ps
// Constant command store. Returns one command bit, chosen by byte index
// and bit index, where bit index 0 is the most significant bit.
// Entries past the command length read as zero.
module mode_cmd_rom
    import mode_cmd_pkg::*;
(
    input  logic [BYTE_CW-1:0] byte_idx_i,
    input  logic [BIT_CW-1:0]  bit_idx_i,
    output logic               bit_o
);

    localparam int DEPTH = 1 << BYTE_CW;

    logic [CMD_W-1:0] tbl [DEPTH];
    logic [CMD_W-1:0] word;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        if (g < CMD_LEN) begin : g_used
            assign tbl[g] = cmd_byte(g);
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    // Byte select, then MSB-first bit select.
    always_comb begin
        word  = tbl[byte_idx_i];
        bit_o = word[BIT_CW'(CMD_W - 1) - bit_idx_i];
    end

endmodule

// File: rtl/mode_cmd_seq.sv
`timescale 1ns/1ps
// Mode-switch command sequencer. On start it pulses the latch, clocks
// four bits in and discards them, and holds the two setup intervals.
// It then shifts the fixed command out on the latch line, MSB first,
// and waits out the tail and recovery intervals before pulsing done.
// Assumes the line multiplexer outside the block gives it the lines
// while busy_o is high. Durations come from CLK_HZ.
module mode_cmd_seq
    import mode_cmd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic line_clk_o,
    output logic line_lat_o
);

    localparam int unsigned C_PULSE   = us2cyc(CLK_HZ, 1);
    localparam int unsigned C_LATCH   = us2cyc(CLK_HZ, 5);
    localparam int unsigned C_HOLD_LO = us2cyc(CLK_HZ, 7212);
    localparam int unsigned C_HOLD_HI = us2cyc(CLK_HZ, 2260);
    localparam int unsigned C_BIT     = us2cyc(CLK_HZ, 22);
    localparam int unsigned C_BYTE    = us2cyc(CLK_HZ, 96);
    localparam int unsigned C_TAIL    = us2cyc(CLK_HZ, 892);
    localparam int unsigned C_RECOV   = us2cyc(CLK_HZ, 60000);
    localparam int unsigned G_BIT     = (C_BIT  > 2*C_PULSE) ? C_BIT  - 2*C_PULSE : 1;
    localparam int unsigned G_BYTE    = (C_BYTE > 2*C_PULSE) ? C_BYTE - 2*C_PULSE : 1;
    localparam int          TW        = $clog2(C_RECOV + C_HOLD_LO + 2);

    seq_st_t              st_q, st_n;
    logic [BIT_CW-1:0]    bit_q, bit_n;
    logic [BYTE_CW-1:0]   byte_q, byte_n;
    logic                 done_q, done_n;
    logic                 ld;
    logic [TW-1:0]        ld_val;
    logic                 t_zero;
    logic                 cmd_bit;
    logic                 last_bit, last_byte;

    mode_cmd_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .zero_o (t_zero)
    );

    mode_cmd_rom u_rom (
        .byte_idx_i (byte_q),
        .bit_idx_i  (bit_q),
        .bit_o      (cmd_bit)
    );

    assign last_bit  = (bit_q  == BIT_CW'(CMD_W - 1));
    assign last_byte = (byte_q == BYTE_CW'(CMD_LEN - 1));

    // Next-state, counter and timer-load decisions.
    always_comb begin
        st_n   = st_q;
        bit_n  = bit_q;
        byte_n = byte_q;
        done_n = 1'b0;
        ld     = 1'b0;
        ld_val = '0;
        if (st_q == ST_IDLE) begin
            if (start_i) begin
                st_n   = ST_LATCH;
                bit_n  = '0;
                byte_n = '0;
                ld     = 1'b1;
                ld_val = TW'(C_LATCH - 1);
            end
        end else if (t_zero) begin
            ld = 1'b1;
            case (st_q)
                ST_LATCH: begin
                    st_n   = ST_RD_LO;
                    ld_val = TW'(C_PULSE - 1);
                end
                ST_RD_LO: begin
                    st_n   = ST_RD_HI;
                    ld_val = TW'(C_PULSE - 1);
                end
                ST_RD_HI: begin
                    if (bit_q == BIT_CW'(READ_BITS - 1)) begin
                        st_n   = ST_HOLD_LO;
                        bit_n  = '0;
                        ld_val = TW'(C_HOLD_LO - 1);
                    end else begin
                        st_n   = ST_RD_LO;
                        bit_n  = bit_q + 1'b1;
                        ld_val = TW'(C_PULSE - 1);
                    end
                end
                ST_HOLD_LO: begin
                    st_n   = ST_HOLD_HI;
                    ld_val = TW'(C_HOLD_HI - 1);
                end
                ST_HOLD_HI: begin
                    st_n   = ST_BIT_SET;
                    ld_val = TW'(C_PULSE - 1);
                end
                ST_BIT_SET: begin
                    st_n   = ST_BIT_LO;
                    ld_val = TW'(C_PULSE - 1);
                end
                ST_BIT_LO: begin
                    st_n = ST_BIT_HI;
                    if (last_bit && last_byte) ld_val = TW'(C_TAIL - 1);
                    else if (last_bit)         ld_val = TW'(G_BYTE - 1);
                    else                       ld_val = TW'(G_BIT - 1);
                end
                ST_BIT_HI: begin
                    if (last_bit && last_byte) begin
                        st_n   = ST_RECOV;
                        ld_val = TW'(C_RECOV - 1);
                    end else begin
                        st_n   = ST_BIT_SET;
                        bit_n  = bit_q + 1'b1;
                        if (last_bit) byte_n = byte_q + 1'b1;
                        ld_val = TW'(C_PULSE - 1);
                    end
                end
                ST_RECOV: begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    ld     = 1'b0;
                end
                default: begin
                    st_n = ST_IDLE;
                    ld   = 1'b0;
                end
            endcase
        end
    end

    // State, counters and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            bit_q  <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            bit_q  <= bit_n;
            byte_q <= byte_n;
            done_q <= done_n;
        end
    end

    // Line drive decoded from the registered state.
    always_comb begin
        line_clk_o = !(st_q == ST_RD_LO || st_q == ST_BIT_LO);
        line_lat_o = (st_q == ST_LATCH) || (st_q == ST_HOLD_HI) ||
                     (((st_q == ST_BIT_SET) || (st_q == ST_BIT_LO) ||
                       (st_q == ST_BIT_HI)) && cmd_bit);
    end

    assign busy_o = (st_q != ST_IDLE);
    assign done_o = done_q;

endmodule

// File: rtl/mode_cmd_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the mode-switch sequencer, bound to every instance.
// Watches only the ports of the sequencer.
module mode_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic line_clk_o,
    input logic line_lat_o
);

    logic was_rst;

    // Remembers that reset was applied at the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: idle line levels after a reset edge.
    always @(posedge clk) begin
        if (was_rst && rst_n) begin
            p_reset_idle_r1: assert (line_clk_o && !line_lat_o && !busy_o && !done_o)
                else $error("R1 idle levels after reset");
        end
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && line_lat_o && line_clk_o));

    p_clk_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_clk_o |-> busy_o);

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_clk_o && $past(!line_clk_o)) |-> $stable(line_lat_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind mode_cmd_seq mode_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .line_clk_o (line_clk_o),
    .line_lat_o (line_lat_o)
);

// File: tb/tb_mode_cmd_seq.sv
`timescale 1ns/1ps
module tb_mode_cmd_seq;

    localparam int unsigned HZ = 100_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, done_o, line_clk_o, line_lat_o;

    always #2 clk = ~clk;

    mode_cmd_seq #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o),
        .line_clk_o(line_clk_o), .line_lat_o(line_lat_o)
    );

    // Expected durations from the requirement formula.
    function automatic int cy(input longint unsigned us);
        longint unsigned v;
        v = (us * HZ + 999_999) / 1_000_000;
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic logic [7:0] exp_byte(input int k);
        logic [7:0] t [7] = '{8'h06, 8'hC1, 8'h08, 8'h00, 8'h02, 8'hFF, 8'h01};
        return t[k];
    endfunction

    function automatic int exp_total();
        return cy(5) + 8*cy(1) + cy(7212) + cy(2260) + 112*cy(1)
             + 49*(cy(22) - 2*cy(1)) + 6*(cy(96) - 2*cy(1))
             + cy(892) + cy(60000);
    endfunction

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Port monitor, sampled on the falling edge.
    int cyc_n = 0;
    bit mon_on = 0;
    logic pclk, plat, lat_at_fall;
    int busy_cnt, done_cnt, done_t, rn, lr_n, lf_n, stab_err, idle_lo_err;
    int rise_t [64];
    logic rise_v [64];
    int lr_t [64];
    int lf_t [64];

    always @(negedge clk) begin
        cyc_n++;
        if (mon_on) begin
            if (busy_o) busy_cnt++;
            if (done_o) begin done_cnt++; done_t = cyc_n; end
            if (!line_clk_o && !busy_o) idle_lo_err++;
            if (!pclk && line_clk_o) begin
                if (rn < 64) begin rise_t[rn] = cyc_n; rise_v[rn] = line_lat_o; end
                if (line_lat_o !== lat_at_fall) stab_err++;
                rn++;
            end
            if (pclk && !line_clk_o) lat_at_fall = line_lat_o;
            if (!plat && line_lat_o && lr_n < 64) begin lr_t[lr_n] = cyc_n; lr_n++; end
            if (plat && !line_lat_o && lf_n < 64) begin lf_t[lf_n] = cyc_n; lf_n++; end
        end
        pclk = line_clk_o;
        plat = line_lat_o;
    end

    task automatic clear_mon();
        busy_cnt = 0; done_cnt = 0; done_t = 0; rn = 0; lr_n = 0; lf_n = 0;
        stab_err = 0; idle_lo_err = 0; lat_at_fall = line_lat_o;
    endtask

    task automatic check_idle(input string req);
        chk(line_clk_o === 1'b1, req, int'(line_clk_o), 1);
        chk(line_lat_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, req,
            int'({line_lat_o, busy_o, done_o}), 0);
    endtask

    // One full sequence; noise toggles start while busy.
    task automatic run_seq(input int gap, input bit noise);
        int guard;
        int spc_err;
        logic [7:0] b;
        repeat (gap) @(negedge clk);
        #1;
        clear_mon();
        mon_on = 1;
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        guard = 0;
        while (done_cnt == 0 && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
            if (done_cnt == 0 && noise) start_i = (($urandom % 40) == 0);
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        mon_on = 0;
        chk(busy_cnt == exp_total(), "R9 busy length", busy_cnt, exp_total());
        chk(done_cnt == 1, noise ? "R10 single done under start noise" : "R9 single done",
            done_cnt, 1);
        chk(rn == 60, noise ? "R10 pulse count under start noise" : "R5 pulse count", rn, 60);
        if (rn == 60 && lf_n >= 2 && lr_n >= 2) begin
            for (int k = 0; k < 7; k++) begin
                for (int j = 0; j < 8; j++) b[7-j] = rise_v[4 + 8*k + j];
                chk(b == exp_byte(k), "R5 command byte", int'(b), int'(exp_byte(k)));
            end
            spc_err = 0;
            for (int k = 5; k < 60; k++) begin
                if (rise_t[k] - rise_t[k-1] != (((k - 4) % 8 == 0) ? cy(96) : cy(22)))
                    spc_err++;
            end
            chk(spc_err == 0, "R7 bit and byte spacing", spc_err, 0);
            chk(lf_t[0] - lr_t[0] == cy(5), "R2 latch pulse width", lf_t[0] - lr_t[0], cy(5));
            chk(rise_t[0] - lf_t[0] == cy(1), "R3 first read low", rise_t[0] - lf_t[0], cy(1));
            chk(rise_t[3] - rise_t[0] == 6*cy(1), "R3 read pulse period",
                rise_t[3] - rise_t[0], 6*cy(1));
            chk(lr_t[1] - rise_t[3] == cy(1) + cy(7212), "R4 quiet hold",
                lr_t[1] - rise_t[3], cy(1) + cy(7212));
            chk(lf_t[1] - lr_t[1] == cy(2260), "R4 latch high hold",
                lf_t[1] - lr_t[1], cy(2260));
            chk(lf_t[lf_n-1] - rise_t[59] == cy(892), "R8 tail wait",
                lf_t[lf_n-1] - rise_t[59], cy(892));
            chk(done_t - lf_t[lf_n-1] == cy(60000), "R8 recovery wait",
                done_t - lf_t[lf_n-1], cy(60000));
        end else begin
            chk(1'b0, "R5 capture incomplete", rn, 60);
        end
        chk(stab_err == 0, "R6 latch stable while clock low", stab_err, 0);
        chk(idle_lo_err == 0, "R3 clock low only while busy", idle_lo_err, 0);
        check_idle("R1 idle after done");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (5) @(negedge clk);
        #1;
        check_idle("R1 reset state");
        rst_n = 1'b1;
        run_seq(3, 1'b0);
        // Reset in the middle of a run.
        @(negedge clk); #1;
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        repeat (300) @(negedge clk);
        #1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check_idle("R1 reset mid-run");
        rst_n = 1'b1;
        for (int r = 0; r < 2; r++) run_seq(1 + ($urandom % 20), 1'b1);
        summary();
    end

    initial begin
        #(4 * 150_000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

endmodule